// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block is the target side of a three-wire serial memory link with a chip select. It holds its own word-organised storage array: 2^ADDR_W words of DATA_W bits, 256 by 16 by default. A host selects the block, clocks in a start bit, a two-bit command and an address, and then either clocks in a word to store or clocks out the stored word. All fields travel most significant bit first and are taken on rising serial-clock edges.

The select, serial-clock and data-in pins are brought into the system clock domain through a synchroniser of SYNC_STAGES flops and then edge-detected. The abort rules therefore resolve the same way every time, even when the select and the serial clock change in the same sample. A read can be abandoned at any point. A write is abandoned only if select falls before the rising edge that carries the last data bit. From that edge on, the write is committed and starts a self-timed write cycle of WR_CYCLES system clocks. While that cycle runs, the data output reports busy and the block refuses new frames.

Top module: `serial_eeprom_target`

## Requirements
- R1: After reset, doOut is low while csIn is low and the block is not busy, so doOut reads high as soon as csIn is raised.
- R2: While the synchronised select is low, doOut is 0, and serial-clock and data-in activity neither starts a frame nor changes any stored word.
- R3: A frame starts on the first rising serial-clock edge that finds data-in high with select high. Earlier rising edges with data-in low are skipped. A rising edge synchronised in the same sample as the rise of select counts, so a select that rises together with a high clock and a high data-in starts a frame.
- R4: Command 2'b10 is a read and 2'b01 is a write. Commands 2'b00 and 2'b11 make the block ignore the rest of the frame until select falls, and leave storage unchanged.
- R5: For a read, the rising edge that carries the last address bit drives doOut to a dummy 0. The next DATA_W rising edges then present the stored word MSB first, one bit per edge.
- R6: For a write, the DATA_W bits after the address are stored MSB first at the addressed word. The store happens on rising edge 3+ADDR_W+DATA_W of the frame, which is edge 27 by default.
- R7: If select falls before that final rising edge, the write is cancelled and the word keeps its old value. A select fall synchronised in the same sample as the final rising edge also cancels the write.
- R8: Dropping select at any point of a read ends it with no effect on storage, and the next frame works normally.
- R9: Once committed, a write is completed even if select falls at once or serial-clock edges continue. Further edges within the same selection are ignored.
- R10: For WR_CYCLES system clocks after a commit, doOut is low whenever select is high outside a read's data phase. After that it returns high.
- R11: Start bits arriving during the write cycle are ignored. The block stays idle and doOut keeps reporting busy.
- R12: With select high and no read data phase in progress, doOut shows readiness: high when no write cycle is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csIn | input | 1 | Chip select from the host, active high, asynchronous |
| skIn | input | 1 | Serial clock from the host, asynchronous |
| diIn | input | 1 | Serial data into the block |
| doOut | output | 1 | Serial data or ready status out of the block, 0 when deselected |

## Verification
The main write and read paths are swept over 64 distinct addresses. The addresses are spread so that every address bit takes both values, and each word's value is computed from its address, so a misplaced address bit or a reversed data bit shows up as a mismatch. Frames are then cut short at chosen edges: a write stopped one edge early, a write whose select drop coincides with the final edge, and reads stopped mid-address and mid-data. These tell the cancel boundary apart from the commit boundary. Committed writes are followed by an immediate deselect, by extra clock edges, and by a new frame during the busy window, which shows that commits cannot be undone and that busy blocks new frames. Leading-zero clocks, the select-with-clock-high start, illegal commands and clocking while deselected check the start-bit and ignore rules.

// File: rtl/sert_pkg.sv
package sert_pkg;
  typedef struct packed {
    logic shiftIn;
    logic loadOut;
    logic shiftOut;
    logic commit;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_RDATA,
    ST_WDATA,
    ST_HOLD
  } state_t;

  localparam logic [1:0] CMD_READ  = 2'b10;
  localparam logic [1:0] CMD_WRITE = 2'b01;
endpackage

// File: rtl/sert_control.sv
module sert_control
  import sert_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int WR_CYCLES   = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csIn,
  input  logic    skIn,
  input  logic    diIn,
  output strobe_t strobe,
  output logic    csS,
  output logic    diS,
  output logic    readPhase,
  output logic    busy
);
  localparam int ADDR_LAST = 3 + ADDR_W;
  localparam int DATA_LAST = ADDR_LAST + DATA_W;
  localparam int CNT_W     = $clog2(DATA_LAST + 1);
  localparam int BUSY_W    = $clog2(WR_CYCLES + 1);

  logic [SYNC_STAGES-1:0] csPipe, skPipe, diPipe;
  logic skS, skPrev, skRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe <= '0;
      skPipe <= '0;
      diPipe <= '0;
      skPrev <= 1'b0;
    end else begin
      csPipe <= {csPipe[SYNC_STAGES-2:0], csIn};
      skPipe <= {skPipe[SYNC_STAGES-2:0], skIn};
      diPipe <= {diPipe[SYNC_STAGES-2:0], diIn};
      skPrev <= skS;
    end
  end

  assign csS    = csPipe[SYNC_STAGES-1];
  assign skS    = skPipe[SYNC_STAGES-1];
  assign diS    = diPipe[SYNC_STAGES-1];
  assign skRise = skS & ~skPrev;

  state_t            state, stateN;
  logic [CNT_W-1:0]  riseCnt, riseCntN;
  logic              opHi, opHiN, isRead, isReadN, readPhaseN;
  logic [BUSY_W-1:0] busyCnt;

  assign busy = (busyCnt != '0);

  always_comb begin
    stateN     = state;
    riseCntN   = riseCnt;
    opHiN      = opHi;
    isReadN    = isRead;
    readPhaseN = readPhase;
    strobe     = '0;
    if (!csS) begin
      stateN     = ST_IDLE;
      riseCntN   = '0;
      readPhaseN = 1'b0;
    end else if (skRise) begin
      case (state)
        ST_IDLE: begin
          if (diS && !busy) begin
            stateN   = ST_OPC;
            riseCntN = CNT_W'(1);
          end
        end
        ST_OPC: begin
          riseCntN = riseCnt + 1'b1;
          if (riseCnt == CNT_W'(1)) begin
            opHiN = diS;
          end else if ({opHi, diS} == CMD_READ) begin
            stateN  = ST_ADDR;
            isReadN = 1'b1;
          end else if ({opHi, diS} == CMD_WRITE) begin
            stateN  = ST_ADDR;
            isReadN = 1'b0;
          end else begin
            stateN = ST_HOLD;
          end
        end
        ST_ADDR: begin
          strobe.shiftIn = 1'b1;
          riseCntN       = riseCnt + 1'b1;
          if (riseCnt == CNT_W'(ADDR_LAST - 1)) begin
            if (isRead) begin
              strobe.loadOut = 1'b1;
              readPhaseN     = 1'b1;
              stateN         = ST_RDATA;
            end else begin
              stateN = ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          strobe.shiftOut = 1'b1;
          riseCntN        = riseCnt + 1'b1;
          if (riseCnt == CNT_W'(DATA_LAST - 1)) stateN = ST_HOLD;
        end
        ST_WDATA: begin
          riseCntN = riseCnt + 1'b1;
          if (riseCnt == CNT_W'(DATA_LAST - 1)) begin
            strobe.commit = 1'b1;
            stateN        = ST_HOLD;
          end else begin
            strobe.shiftIn = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      riseCnt   <= '0;
      opHi      <= 1'b0;
      isRead    <= 1'b0;
      readPhase <= 1'b0;
      busyCnt   <= '0;
    end else begin
      state     <= stateN;
      riseCnt   <= riseCntN;
      opHi      <= opHiN;
      isRead    <= isReadN;
      readPhase <= readPhaseN;
      if (strobe.commit)   busyCnt <= BUSY_W'(WR_CYCLES);
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end
  end

  // R2
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csS |=> (state == ST_IDLE));

  // R11
  busy_blocks_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && state == ST_IDLE) |=> (state == ST_IDLE));

  // R10
  commit_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> busy);

  // R10
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= BUSY_W'(WR_CYCLES));
endmodule

// File: rtl/sert_datapath.sv
module sert_datapath
  import sert_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobe,
  input  logic    csS,
  input  logic    diS,
  input  logic    readPhase,
  input  logic    busy,
  output logic    doOut
);
  localparam int SH_W  = ADDR_W + DATA_W - 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [SH_W-1:0]   inShift;
  logic [DATA_W-1:0] outShift;
  logic              doBit;
  logic [DATA_W-1:0] mem [DEPTH];

  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [DATA_W-1:0] wrData;

  assign rdAddr = {inShift[ADDR_W-2:0], diS};
  assign wrAddr = inShift[SH_W-1 -: ADDR_W];
  assign wrData = {inShift[DATA_W-2:0], diS};

  always_ff @(posedge clk) begin
    if (strobe.commit) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift  <= '0;
      outShift <= '0;
      doBit    <= 1'b0;
    end else begin
      if (strobe.shiftIn) inShift <= {inShift[SH_W-2:0], diS};
      if (strobe.loadOut) begin
        outShift <= mem[rdAddr];
        doBit    <= 1'b0;
      end else if (strobe.shiftOut) begin
        doBit    <= outShift[DATA_W-1];
        outShift <= {outShift[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign doOut = csS & (readPhase ? doBit : ~busy);

  // R5
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadOut |=> !doOut);

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.shiftIn | strobe.loadOut, strobe.shiftOut, strobe.commit}));
endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target
  import sert_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int WR_CYCLES   = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  output logic doOut
);
  strobe_t strobe;
  logic    csS, diS, readPhase, busy;

  sert_control #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .WR_CYCLES(WR_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) u_control (
    .clk(clk), .rstN(rstN), .csIn(csIn), .skIn(skIn), .diIn(diIn),
    .strobe(strobe), .csS(csS), .diS(diS), .readPhase(readPhase), .busy(busy)
  );

  sert_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .csS(csS), .diS(diS),
    .readPhase(readPhase), .busy(busy), .doOut(doOut)
  );
endmodule

// File: tb/serial_eeprom_target_bench.sv
module serial_eeprom_target_bench;
  localparam int H  = 4;
  localparam int WR = 300;

  logic clk = 1'b0, rstN = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic doOut;
  int checks = 0, fails = 0;
  logic [15:0] model [256];

  serial_eeprom_target #(.WR_CYCLES(WR)) u_serial_eeprom_target (
    .clk(clk), .rstN(rstN), .csIn(cs), .skIn(sk), .diIn(di), .doOut(doOut)
  );

  always #5 clk = ~clk;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, output logic samp);
    di = b;
    waitClk(H);
    sk = 1'b1;
    waitClk(H);
    samp = doOut;
    sk = 1'b0;
  endtask

  task automatic frame(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d,
                       input int first, input int last,
                       output logic [15:0] rd, output logic dummy);
    logic [26:0] bits;
    logic s;
    bits  = {1'b1, op, a, d};
    rd    = '0;
    dummy = 1'b0;
    for (int k = first; k <= last; k++) begin
      sendBit(bits[27-k], s);
      if (k == 11) dummy = s;
      if (k >= 12) rd[27-k] = s;
    end
  endtask

  task automatic csUp;
    cs = 1'b1;
    waitClk(H);
  endtask

  task automatic csDown;
    waitClk(H);
    cs = 1'b0;
    waitClk(H + 4);
  endtask

  task automatic writeWord(input logic [7:0] a, input logic [15:0] d);
    logic [15:0] rd;
    logic dm;
    csUp();
    frame(2'b01, a, d, 1, 27, rd, dm);
    csDown();
    waitClk(WR + 10);
    model[a] = d;
  endtask

  task automatic readWord(input logic [7:0] a, output logic [15:0] rd, output logic dm);
    csUp();
    frame(2'b10, a, 16'h0000, 1, 27, rd, dm);
    csDown();
  endtask

  function automatic logic [7:0] addrOf(input int i);
    return 8'((i * 37 + 5) % 256);
  endfunction

  function automatic logic [15:0] dataOf(input logic [7:0] a, input int i);
    return (16'(a) * 16'h0101) ^ 16'h5A3C ^ 16'(i << 3);
  endfunction

  initial begin : watchdog
    waitClk(190000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [15:0] rd;
    logic dm, s;
    logic [7:0] a0, a1, a2, a4, a5, a6, a7, a8;

    waitClk(10);
    rstN = 1'b1;
    waitClk(4);
    chk(16'(doOut), 16'h0, "R1 deselected after reset");
    csUp();
    waitClk(4);
    chk(16'(doOut), 16'h1, "R1/R12 ready after reset");
    cs = 1'b0;
    waitClk(H + 4);

    // R6/R10: first write with busy timing
    a0 = addrOf(0);
    csUp();
    frame(2'b01, a0, dataOf(a0, 0), 1, 27, rd, dm);
    chk(16'(doOut), 16'h0, "R10 busy right after commit");
    waitClk(WR - 30);
    chk(16'(doOut), 16'h0, "R10 still busy");
    waitClk(50);
    chk(16'(doOut), 16'h1, "R10 ready after write cycle");
    csDown();
    model[a0] = dataOf(a0, 0);

    // R6: write sweep
    for (int i = 1; i < 64; i++) writeWord(addrOf(i), dataOf(addrOf(i), i));
    // R5: read sweep
    for (int i = 0; i < 64; i++) begin
      readWord(addrOf(i), rd, dm);
      chk(16'(dm), 16'h0, "R5 dummy bit");
      chk(rd, model[addrOf(i)], "R5/R6 readback");
    end

    a1 = addrOf(1); a2 = addrOf(2); a4 = addrOf(4); a5 = addrOf(5);
    a6 = addrOf(6); a7 = addrOf(7); a8 = addrOf(8);

    // R3: leading zero clocks skipped
    csUp();
    sendBit(1'b0, s); sendBit(1'b0, s); sendBit(1'b0, s);
    frame(2'b10, a2, 16'h0, 1, 27, rd, dm);
    csDown();
    chk(rd, model[a2], "R3 leading zeros skipped");

    // R3: select rising together with high clock and data is a start bit
    di = 1'b1; cs = 1'b1; sk = 1'b1;
    waitClk(H);
    sk = 1'b0;
    frame(2'b10, a1, 16'h0, 2, 27, rd, dm);
    csDown();
    chk(rd, model[a1], "R3 select with clock high taken as start");

    // R4: illegal commands ignore the rest of the frame
    csUp();
    frame(2'b11, a0, 16'h1234, 1, 27, rd, dm);
    chk(16'(doOut), 16'h1, "R4 cmd 11 ignored, not busy");
    csDown();
    csUp();
    frame(2'b00, a0, 16'h4321, 1, 27, rd, dm);
    chk(16'(doOut), 16'h1, "R4 cmd 00 ignored, not busy");
    csDown();
    readWord(a0, rd, dm);
    chk(rd, model[a0], "R4 storage unchanged by illegal commands");

    // R7: cancel one edge early
    csUp();
    frame(2'b01, a1, ~model[a1], 1, 26, rd, dm);
    chk(16'(doOut), 16'h1, "R7 not busy before final edge");
    csDown();
    readWord(a1, rd, dm);
    chk(rd, model[a1], "R7 early cancel leaves word");

    // R7: select fall in same sample as final edge
    csUp();
    frame(2'b01, a1, ~model[a1], 1, 26, rd, dm);
    di = ~model[a1][0];
    waitClk(H);
    sk = 1'b1; cs = 1'b0;
    waitClk(H);
    sk = 1'b0;
    waitClk(4);
    chk(16'(doOut), 16'h0, "R2 deselected output low");
    csUp();
    waitClk(2);
    chk(16'(doOut), 16'h1, "R7 coincident deselect leaves block ready");
    cs = 1'b0;
    waitClk(H + 4);
    readWord(a1, rd, dm);
    chk(rd, model[a1], "R7 coincident deselect cancels write");

    // R8: read cancels
    csUp();
    frame(2'b10, a2, 16'h0, 1, 15, rd, dm);
    csDown();
    csUp();
    frame(2'b10, a2, 16'h0, 1, 6, rd, dm);
    csDown();
    readWord(a2, rd, dm);
    chk(rd, model[a2], "R8 read after cancelled reads");

    // R9: deselect right after commit, clocks while deselected
    csUp();
    frame(2'b01, a4, 16'hBEEF, 1, 27, rd, dm);
    cs = 1'b0;
    for (int k = 0; k < 20; k++) sendBit(1'b1, s);
    chk(16'(s), 16'h0, "R2 output low while deselected");
    waitClk(WR);
    model[a4] = 16'hBEEF;
    readWord(a4, rd, dm);
    chk(rd, 16'hBEEF, "R9 commit survives deselect");

    // R9: extra clocks with select held
    csUp();
    frame(2'b01, a5, 16'h0F0F, 1, 27, rd, dm);
    for (int k = 0; k < 10; k++) sendBit(1'b1, s);
    chk(16'(s), 16'h0, "R9/R10 busy through extra clocks");
    csDown();
    waitClk(WR);
    model[a5] = 16'h0F0F;
    readWord(a5, rd, dm);
    chk(rd, 16'h0F0F, "R9 commit survives extra clocks");

    // R11: start bit during write cycle ignored
    writeWord(a7, 16'hC0DF);
    csUp();
    frame(2'b01, a6, 16'h1357, 1, 27, rd, dm);
    csDown();
    csUp();
    frame(2'b10, a7, 16'h0, 1, 12, rd, dm);
    chk({dm, rd[15]}, 16'h0, "R11 read ignored while busy");
    chk(16'(doOut), 16'h0, "R11 busy status shown");
    csDown();
    waitClk(WR);
    model[a6] = 16'h1357;
    readWord(a7, rd, dm);
    chk(rd, 16'hC0DF, "R11 later read works");
    readWord(a6, rd, dm);
    chk(rd, 16'h1357, "R11 committed word");

    // R2: full write frame while deselected
    cs = 1'b0;
    frame(2'b01, a8, ~model[a8], 1, 27, rd, dm);
    chk(rd, 16'h0, "R2 output low during deselected clocks");
    waitClk(WR);
    readWord(a8, rd, dm);
    chk(rd, model[a8], "R2 storage unchanged while deselected");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule